// File: doc/BRIEF.md
# Keyboard Event Capture Interface

This block sits between a keyboard decoder and a processor's memory-mapped I/O bus. The decoder supplies three things: an ASCII code with its own new-key indication, a special-key code with its own new-key indication, and the state of three modifier keys. Either indication may be a one-cycle pulse or a level that stays high for many cycles. The block turns each rising edge into one key event. It packs the codes, a type flag for each kind of key and the modifier state of that cycle into one 21-bit entry, and pushes the entry into an eight-entry queue.

The processor sees two registers. The status word reports whether the oldest queued key is an ASCII key or a special key, and carries a sticky bit that is set when a key was lost because the queue was full. The data word always shows the oldest entry. A read strobe on the data word removes that entry at the end of the cycle, so no handshake is needed.

Every register runs on the single system clock. The indications are sampled as data and are never used as clocks or enables of storage elements.

Top module: `key_event_capture`

## Requirements
- R1: A new-key input held high for any number of cycles makes exactly one event, on its rising edge; the event is written at the clock edge that first samples the input high.
- R2: An entry is laid out as ASCII code in bits 7:0, special code in bits 15:8, ASCII-valid flag in bit 16, special-valid flag in bit 17 and modifiers in bits 20:18. The modifiers are those present in the event cycle, and the code field of a kind that did not arrive reads zero.
- R3: When both new-key inputs rise in the same cycle, one entry is stored with both flags and both codes set.
- R4: The data output shows the oldest entry in the same cycle, combinationally. A data read removes that entry at the clock edge, and entries come out in arrival order.
- R5: Status bit 0 is 1 when the oldest entry carries the ASCII flag, and bit 1 is 1 when it carries the special flag. Both read 0 when the queue is empty, and both are valid in the cycle they are sampled.
- R6: The queue holds 8 entries. An event that arrives while the queue is full and no data read is made is dropped, and the 8 stored entries are kept.
- R7: Status bit 2 is set by a dropped event. It stays set until a status read, which still returns 1, and reads 0 from the next cycle on.
- R8: An event and a data read in the same cycle both take effect, so the entry count is unchanged. This holds when the queue is full, and in that case nothing is dropped.
- R9: A data read of an empty queue returns zero and leaves the queue unchanged.
- R10: After reset the status word and the data word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ascii_stb | input | 1 | New ASCII key indication, pulse or level |
| ascii_code | input | 8 | Decoded ASCII code |
| spec_stb | input | 1 | New special key indication, pulse or level |
| spec_code | input | 8 | Decoded special-key code |
| mod_keys | input | 3 | Modifier key states |
| data_rd | input | 1 | Processor reads the data word; removes the oldest entry |
| stat_rd | input | 1 | Processor reads the status word; clears the overflow bit |
| key_data | output | 21 | Oldest queued entry, zero when empty |
| key_status | output | 3 | {overflow, special pending, ASCII pending} |

## Verification
The clash of interest is a rising new-key input and a processor data read landing on the same clock edge, first with a partly filled queue and then with a full one. The bench raises the input and the read strobe on the same falling edge and checks the head entry seen during that cycle. It then drains the queue and compares every entry in arrival order, and checks that the overflow bit stayed clear in the full case. Losing the new event, losing the popped entry, or raising a false overflow each show up as a wrong drained sequence or status word.

// File: rtl/kec_pkg.sv
package kec_pkg;
  localparam int KEC_CODE_W = 8;
  localparam int KEC_MOD_W  = 3;

  typedef struct packed {
    logic [KEC_MOD_W-1:0]  mods;
    logic                  spec_v;
    logic                  ascii_v;
    logic [KEC_CODE_W-1:0] spec;
    logic [KEC_CODE_W-1:0] ascii;
  } kec_entry_t;

  localparam int KEC_ENTRY_W = $bits(kec_entry_t);
endpackage

// File: rtl/kec_rise.sv
module kec_rise #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] pulse
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  always_comb pulse = lvl & ~prev_q;

  // one event per rising edge: a pulse is never followed by another pulse
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_chk
      assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pulse[gi] |=> !pulse[gi]);
    end
  endgenerate
endmodule

// File: rtl/kec_fifo.sv
module kec_fifo #(
  parameter int W     = 21,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         dropped
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  always_comb begin
    empty   = (cnt_q == '0);
    full    = (cnt_q == CNT_W'(DEPTH));
    do_pop  = pop & ~empty;
    do_push = push & (~full | do_pop);
    dropped = push & full & ~do_pop;
    dout    = mem[rd_q];
  end

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  assert_full_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(wr_q));
  assert_same_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty) |=> $stable(cnt_q));
  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> ($stable(rd_q) && $stable(wr_q)));
endmodule

// File: rtl/key_event_capture.sv
module key_event_capture #(
  parameter int DEPTH = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                ascii_stb,
  input  logic [kec_pkg::KEC_CODE_W-1:0]      ascii_code,
  input  logic                                spec_stb,
  input  logic [kec_pkg::KEC_CODE_W-1:0]      spec_code,
  input  logic [kec_pkg::KEC_MOD_W-1:0]       mod_keys,
  input  logic                                data_rd,
  input  logic                                stat_rd,
  output logic [kec_pkg::KEC_ENTRY_W-1:0]     key_data,
  output logic [2:0]                          key_status
);
  import kec_pkg::*;

  logic [1:0]  evt;
  logic        push, empty, full, dropped;
  kec_entry_t  new_e, head_e;
  logic [KEC_ENTRY_W-1:0] head_raw;
  logic        ovf_q, ovf_d;

  kec_rise #(.N(2)) u_rise (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   ({spec_stb, ascii_stb}),
    .pulse (evt)
  );

  always_comb begin
    push         = evt[0] | evt[1];
    new_e.mods   = mod_keys;
    new_e.ascii_v = evt[0];
    new_e.spec_v  = evt[1];
    new_e.ascii  = evt[0] ? ascii_code : '0;
    new_e.spec   = evt[1] ? spec_code  : '0;
  end

  kec_fifo #(.W(KEC_ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push),
    .din     (new_e),
    .pop     (data_rd),
    .dout    (head_raw),
    .empty   (empty),
    .full    (full),
    .dropped (dropped)
  );

  always_comb begin
    head_e     = head_raw;
    key_data   = empty ? '0 : head_raw;
    key_status = {ovf_q, head_e.spec_v & ~empty, head_e.ascii_v & ~empty};
    ovf_d      = dropped | (ovf_q & ~stat_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assert_ovf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dropped |=> key_status[2]);
  assert_ovf_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !dropped) |=> !key_status[2]);
  assert_no_drop_on_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && full) |-> !dropped);
endmodule

// File: tb/sim_key_event_capture.sv
module sim_key_event_capture;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ascii_stb, spec_stb, data_rd, stat_rd;
  logic [7:0]  ascii_code, spec_code;
  logic [2:0]  mod_keys;
  logic [20:0] key_data;
  logic [2:0]  key_status;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  key_event_capture u0 (
    .clk(clk), .rst_n(rst_n), .ascii_stb(ascii_stb), .ascii_code(ascii_code),
    .spec_stb(spec_stb), .spec_code(spec_code), .mod_keys(mod_keys),
    .data_rd(data_rd), .stat_rd(stat_rd), .key_data(key_data), .key_status(key_status)
  );

  function automatic logic [20:0] mk(logic av, logic sv, logic [7:0] a, logic [7:0] s, logic [2:0] m);
    return {m, sv, av, sv ? s : 8'h00, av ? a : 8'h00};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push_a(logic [7:0] a, logic [2:0] m, int hold);
    ascii_code = a; mod_keys = m; ascii_stb = 1'b1;
    repeat (hold) tick();
    ascii_stb = 1'b0; ascii_code = 8'h00;
    tick();
  endtask

  task automatic pop_chk(string tag, logic [20:0] exp);
    data_rd = 1'b1;
    #1 chk(tag, 32'(key_data), 32'(exp));
    tick();
    data_rd = 1'b0;
  endtask

  task automatic t_reset();
    #1 chk("R10 status after reset", 32'(key_status), 0);
    chk("R10 data after reset", 32'(key_data), 0);
  endtask

  task automatic t_held_ascii();
    ascii_code = 8'h41; mod_keys = 3'b101; ascii_stb = 1'b1;
    tick();
    mod_keys = 3'b010;
    repeat (4) tick();
    ascii_stb = 1'b0; tick();
    #1 chk("R5 ascii pending", 32'(key_status), 1);
    pop_chk("R2 held ascii entry with event-cycle mods", mk(1, 0, 8'h41, 0, 3'b101));
    #1 chk("R1 one event for held level", 32'(key_status), 0);
  endtask

  task automatic t_special();
    spec_code = 8'h12; mod_keys = 3'b011; spec_stb = 1'b1;
    tick(); spec_stb = 1'b0; tick();
    #1 chk("R5 special pending", 32'(key_status), 2);
    pop_chk("R2 special entry", mk(0, 1, 0, 8'h12, 3'b011));
  endtask

  task automatic t_both();
    ascii_code = 8'h61; spec_code = 8'h05; mod_keys = 3'b100;
    ascii_stb = 1'b1; spec_stb = 1'b1;
    tick(); ascii_stb = 1'b0; spec_stb = 1'b0; tick();
    #1 chk("R3 both pending", 32'(key_status), 3);
    pop_chk("R3 combined entry", mk(1, 1, 8'h61, 8'h05, 3'b100));
    #1 chk("R3 single entry only", 32'(key_status), 0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 10; i++) push_a(8'(8'h10 + i), 3'(i), 1);
    stat_rd = 1'b1;
    #1 chk("R7 overflow seen on status read", 32'(key_status), 5);
    tick(); stat_rd = 1'b0;
    #1 chk("R7 overflow cleared after read", 32'(key_status), 1);
    for (int i = 0; i < 8; i++) pop_chk("R4 R6 order after overflow", mk(1, 0, 8'(8'h10 + i), 0, 3'(i)));
    #1 chk("R6 queue holds only eight", 32'(key_status), 0);
  endtask

  task automatic t_same_cycle();
    push_a(8'h51, 0, 1);
    push_a(8'h52, 0, 1);
    ascii_code = 8'h53; ascii_stb = 1'b1; data_rd = 1'b1;
    #1 chk("R8 head during push+pop", 32'(key_data), 32'(mk(1, 0, 8'h51, 0, 0)));
    tick(); ascii_stb = 1'b0; data_rd = 1'b0; tick();
    pop_chk("R8 second after push+pop", mk(1, 0, 8'h52, 0, 0));
    pop_chk("R8 new entry kept", mk(1, 0, 8'h53, 0, 0));
    #1 chk("R8 count unchanged then drained", 32'(key_status), 0);
  endtask

  task automatic t_full_same_cycle();
    for (int i = 0; i < 8; i++) push_a(8'(8'h20 + i), 0, 1);
    ascii_code = 8'h30; ascii_stb = 1'b1; data_rd = 1'b1;
    #1 chk("R8 head when full", 32'(key_data), 32'(mk(1, 0, 8'h20, 0, 0)));
    tick(); ascii_stb = 1'b0; data_rd = 1'b0; tick();
    #1 chk("R8 no overflow when pop frees room", 32'(key_status), 1);
    for (int i = 1; i < 8; i++) pop_chk("R8 full drain order", mk(1, 0, 8'(8'h20 + i), 0, 0));
    pop_chk("R8 event accepted while full", mk(1, 0, 8'h30, 0, 0));
    #1 chk("R8 empty after full drain", 32'(key_status), 0);
  endtask

  task automatic t_empty_read();
    pop_chk("R9 empty read returns zero", 0);
    pop_chk("R9 second empty read returns zero", 0);
    push_a(8'h7a, 3'b111, 1);
    pop_chk("R9 queue intact after empty reads", mk(1, 0, 8'h7a, 0, 3'b111));
    #1 chk("R9 empty again", 32'(key_status), 0);
  endtask

  initial begin
    rst_n = 1'b0; ascii_stb = 0; spec_stb = 0; data_rd = 0; stat_rd = 0;
    ascii_code = 0; spec_code = 0; mod_keys = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_held_ascii();
    t_special();
    t_both();
    t_overflow();
    t_same_cycle();
    t_full_same_cycle();
    t_empty_read();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule